// File: doc/BRIEF.md
# Radix-2 FFT Address Generator

This block sequences a 512-point radix-2 decimation-in-time FFT. After a start pulse it steps through nine stages of 256 butterflies, one butterfly per clock. For each butterfly it presents several values at once:

- the two operand read addresses and the two result write addresses;
- the twiddle-factor index;
- the sub-bank of each operand;
- which of the two memory pairs is the source and which is the destination.

The butterfly arithmetic, the twiddle ROM and the data RAMs sit outside and consume these outputs directly.

Data move between two memory pairs in ping-pong fashion. Each pair is split into two sub-banks, chosen by the parity of the address. The two operands of any butterfly therefore always fall in different sub-banks and can be accessed in the same cycle. Input samples are stored in natural order. The first stage reads them through bit-reversed addresses, which gives the ordering that decimation in time needs. All later stages, and every write, use natural addresses.

Top module: `fft_agu`

## Requirements
- R1: A start pulse makes `busy` high for exactly 9 × 256 = 2304 cycles. During each of those cycles `stage_idx` (s) and `bfly_idx` (j) name the current butterfly. j counts 0 to 255 one step per clock, then wraps to 0 while s advances, from 0 up to 8.
- R2: Synchronous reset leaves `busy`, `done`, `stage_idx`, `bfly_idx` and `rd_pair` at 0. A start pulse, even in the middle of a run, restarts the sequence at s = 0, j = 0 with `rd_pair` = 0 on the next cycle.
- R3: The write operand addresses are formed from j as follows. `wr_addr0` is j with a 0 inserted at bit position s, so the bits of j at and above s move up by one. `wr_addr1` equals `wr_addr0` with bit s set.
- R4: In stages 1 to 8 the read addresses equal the write addresses. In stage 0, `rd_addr0` and `rd_addr1` are the 9-bit bit-reversals of the write addresses.
- R5: `tw_addr` takes the s least significant bits of j and places them at the top of the 8-bit field. Numerically this is (j mod 2^s) × 2^(8−s), so stage 0 always gives 0.
- R6: Each sub-bank output is the XOR of all 9 bits of its address. The two operands of every butterfly are always in opposite sub-banks.
- R7: `rd_pair` is 0 in stage 0 and toggles at every stage boundary. `wr_pair` is always its inverse.
- R8: `done` is a one-cycle pulse in the cycle after the last butterfly (s = 8, j = 255). In that same cycle `busy` is low and `stage_idx`, `bfly_idx` and `rd_pair` are back at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins or restarts a transform |
| busy | output | 1 | High while butterfly outputs are valid |
| done | output | 1 | One-cycle pulse after the final butterfly |
| stage_idx | output | 9 | Current stage s |
| bfly_idx | output | 9 | Current butterfly j within the stage |
| rd_addr0 | output | 9 | Read address of operand 0 |
| rd_addr1 | output | 9 | Read address of operand 1 |
| rd_sub0 | output | 1 | Sub-bank of read operand 0 |
| rd_sub1 | output | 1 | Sub-bank of read operand 1 |
| wr_addr0 | output | 9 | Write address of result 0 |
| wr_addr1 | output | 9 | Write address of result 1 |
| wr_sub0 | output | 1 | Sub-bank of write result 0 |
| wr_sub1 | output | 1 | Sub-bank of write result 1 |
| tw_addr | output | 8 | Twiddle-factor index |
| rd_pair | output | 1 | Memory pair read in this stage |
| wr_pair | output | 1 | Memory pair written in this stage |

## Verification
The bench walks complete transforms and compares every butterfly of every stage against reference functions. It therefore hits several edges that a design could get wrong:

- At the stage 0/1 boundary the read addresses must stop being bit-reversed. A design that reversed in the wrong stages would scramble the transform.
- In stage 8 the inserted bit is the top bit. Shift code that overflows there would fold addresses back onto the lower half.
- The stage-0 twiddle index must be 0; a design that got it wrong would rotate the first butterflies.
- The final butterfly must produce `done` with the pair select cleared; an off-by-one would skip or repeat a stage.

Restarts at random points, including one in the final stage, and a reset in mid-run check that a restart clears all state. Stale counters or a stale pair select would show up as a mismatch on the first butterfly after the restart.

// File: rtl/fft_agu_pkg.sv
package fft_agu_pkg;

    localparam int FFT_LOG2N = 9;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic {
        PAIR_LO = 1'b0,
        PAIR_HI = 1'b1
    } pair_sel_e;

    function automatic pair_sel_e other_pair(input pair_sel_e p);
        return (p == PAIR_LO) ? PAIR_HI : PAIR_LO;
    endfunction

endpackage

// File: rtl/fft_agu_seq.sv
module fft_agu_seq
    import fft_agu_pkg::*;
#(
    parameter int LOG2N = FFT_LOG2N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy_o,
    output logic             done_o,
    output logic [LOG2N-1:0] stage_o,
    output logic [LOG2N-2:0] bfly_o,
    output pair_sel_e        pair_o
);
    localparam int CNT_W    = LOG2N;
    localparam int BF_W     = LOG2N - 1;
    localparam int NBF      = (1 << LOG2N) / 2;
    localparam logic [CNT_W-1:0] LAST_STAGE = CNT_W'(LOG2N - 1);
    localparam logic [BF_W-1:0]  LAST_BFLY  = BF_W'(NBF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] stage;
        logic [BF_W-1:0]  bfly;
    } ctr_t;

    seq_state_e state_q;
    ctr_t       ctr_q;
    pair_sel_e  pair_q;
    logic       done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            ctr_q   <= '0;
            pair_q  <= PAIR_LO;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                state_q <= SEQ_RUN;
                ctr_q   <= '0;
                pair_q  <= PAIR_LO;
            end else if (state_q == SEQ_RUN) begin
                if (ctr_q.bfly == LAST_BFLY) begin
                    ctr_q.bfly <= '0;
                    if (ctr_q.stage == LAST_STAGE) begin
                        state_q     <= SEQ_IDLE;
                        ctr_q.stage <= '0;
                        pair_q      <= PAIR_LO;
                        done_q      <= 1'b1;
                    end else begin
                        ctr_q.stage <= ctr_q.stage + 1'b1;
                        pair_q      <= other_pair(pair_q);
                    end
                end else begin
                    ctr_q.bfly <= ctr_q.bfly + 1'b1;
                end
            end
        end
    end

    assign busy_o  = (state_q == SEQ_RUN);
    assign done_o  = done_q;
    assign stage_o = ctr_q.stage;
    assign bfly_o  = ctr_q.bfly;
    assign pair_o  = pair_q;

    AST_STAGE_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (stage_o <= LAST_STAGE)); // R1

    AST_BFLY_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !start && bfly_o != LAST_BFLY) |=> (bfly_o == $past(bfly_o) + 1'b1) && busy_o); // R1

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy_o && stage_o == '0 && bfly_o == '0 && pair_o == PAIR_LO)); // R2

    AST_PAIR_SWAP: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !start && bfly_o == LAST_BFLY && stage_o != LAST_STAGE) |=> (pair_o != $past(pair_o))); // R7

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !start && bfly_o == LAST_BFLY && stage_o == LAST_STAGE) |=> (done_o && !busy_o)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8

endmodule

// File: rtl/fft_agu_operand.sv
module fft_agu_operand #(
    parameter int LOG2N     = fft_agu_pkg::FFT_LOG2N,
    parameter bit REV_FIRST = 1'b0
) (
    input  logic [LOG2N-1:0] stage_i,
    input  logic [LOG2N-2:0] bfly_i,
    output logic [LOG2N-1:0] addr0_o,
    output logic [LOG2N-1:0] addr1_o,
    output logic             sub0_o,
    output logic             sub1_o
);
    localparam int AW = LOG2N;
    localparam int BW = LOG2N - 1;

    logic [AW-1:0] nat0, nat1, span_bit;

    always_comb begin
        nat0     = '0;
        span_bit = '0;
        for (int i = 0; i < AW; i++) begin
            if (i < int'(stage_i)) begin
                nat0[i] = bfly_i[(i < BW) ? i : 0];
            end else if (i > int'(stage_i)) begin
                nat0[i] = bfly_i[(i > 0) ? i - 1 : 0];
            end
            if (i == int'(stage_i)) begin
                span_bit[i] = 1'b1;
            end
        end
        nat1 = nat0 | span_bit;
    end

    generate
        if (REV_FIRST) begin : g_rev
            logic [AW-1:0] rev0, rev1;
            always_comb begin
                for (int i = 0; i < AW; i++) begin
                    rev0[i] = nat0[AW-1-i];
                    rev1[i] = nat1[AW-1-i];
                end
            end
            assign addr0_o = (stage_i == '0) ? rev0 : nat0;
            assign addr1_o = (stage_i == '0) ? rev1 : nat1;
        end else begin : g_nat
            assign addr0_o = nat0;
            assign addr1_o = nat1;
        end
    endgenerate

    assign sub0_o = ^addr0_o;
    assign sub1_o = ^addr1_o;

endmodule

// File: rtl/fft_agu_twiddle.sv
module fft_agu_twiddle #(
    parameter int LOG2N = fft_agu_pkg::FFT_LOG2N
) (
    input  logic [LOG2N-1:0] stage_i,
    input  logic [LOG2N-2:0] bfly_i,
    output logic [LOG2N-2:0] tw_o
);
    localparam int TW = LOG2N - 1;

    always_comb begin
        tw_o = '0;
        for (int k = 0; k < TW; k++) begin
            int src;
            src = k - (TW - int'(stage_i));
            if (src >= 0 && src < TW) begin
                tw_o[k] = bfly_i[(k < TW) ? src : 0];
            end
        end
    end

endmodule

// File: rtl/fft_agu.sv
module fft_agu
    import fft_agu_pkg::*;
#(
    parameter int LOG2N = FFT_LOG2N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [LOG2N-1:0] stage_idx,
    output logic [LOG2N-1:0] bfly_idx,
    output logic [LOG2N-1:0] rd_addr0,
    output logic [LOG2N-1:0] rd_addr1,
    output logic             rd_sub0,
    output logic             rd_sub1,
    output logic [LOG2N-1:0] wr_addr0,
    output logic [LOG2N-1:0] wr_addr1,
    output logic             wr_sub0,
    output logic             wr_sub1,
    output logic [LOG2N-2:0] tw_addr,
    output logic             rd_pair,
    output logic             wr_pair
);
    localparam int NPORT = 2;

    logic [LOG2N-2:0] bfly;
    pair_sel_e        pair;
    logic [LOG2N-1:0] a0 [NPORT];
    logic [LOG2N-1:0] a1 [NPORT];
    logic             s0 [NPORT];
    logic             s1 [NPORT];

    fft_agu_seq #(.LOG2N(LOG2N)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .busy_o  (busy),
        .done_o  (done),
        .stage_o (stage_idx),
        .bfly_o  (bfly),
        .pair_o  (pair)
    );

    // port 0 = read (stage-0 bit reversal), port 1 = write (natural)
    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            fft_agu_operand #(.LOG2N(LOG2N), .REV_FIRST(p == 0)) u_oper (
                .stage_i (stage_idx),
                .bfly_i  (bfly),
                .addr0_o (a0[p]),
                .addr1_o (a1[p]),
                .sub0_o  (s0[p]),
                .sub1_o  (s1[p])
            );
        end
    endgenerate

    fft_agu_twiddle #(.LOG2N(LOG2N)) u_tw (
        .stage_i (stage_idx),
        .bfly_i  (bfly),
        .tw_o    (tw_addr)
    );

    assign bfly_idx = {1'b0, bfly};
    assign rd_addr0 = a0[0];
    assign rd_addr1 = a1[0];
    assign rd_sub0  = s0[0];
    assign rd_sub1  = s1[0];
    assign wr_addr0 = a0[1];
    assign wr_addr1 = a1[1];
    assign wr_sub0  = s0[1];
    assign wr_sub1  = s1[1];
    assign rd_pair  = pair;
    assign wr_pair  = ~pair;

    AST_OPER_SPAN: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones(wr_addr0 ^ wr_addr1) == 1)); // R3

    AST_READ_MATCH: assert property (@(posedge clk) disable iff (rst)
        (busy && stage_idx != '0) |-> (rd_addr0 == wr_addr0 && rd_addr1 == wr_addr1)); // R4

    AST_TW_STAGE0: assert property (@(posedge clk) disable iff (rst)
        (busy && stage_idx == '0) |-> (tw_addr == '0)); // R5

    AST_SUB_SPLIT: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rd_sub0 != rd_sub1 && wr_sub0 != wr_sub1)); // R6

    AST_PAIR_OPPOSE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rd_pair != wr_pair)); // R7

endmodule

// File: tb/fft_agu_tb.sv
module fft_agu_tb;
    localparam int LG    = 9;
    localparam int NBF   = 256;
    localparam int TOTAL = LG * NBF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, rd_sub0, rd_sub1, wr_sub0, wr_sub1, rd_pair, wr_pair;
    logic [8:0] stage_idx, bfly_idx, rd_addr0, rd_addr1, wr_addr0, wr_addr1;
    logic [7:0] tw_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    fft_agu u_dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .stage_idx(stage_idx), .bfly_idx(bfly_idx),
        .rd_addr0(rd_addr0), .rd_addr1(rd_addr1), .rd_sub0(rd_sub0), .rd_sub1(rd_sub1),
        .wr_addr0(wr_addr0), .wr_addr1(wr_addr1), .wr_sub0(wr_sub0), .wr_sub1(wr_sub1),
        .tw_addr(tw_addr), .rd_pair(rd_pair), .wr_pair(wr_pair)
    );

    function automatic int ins_zero(input int s, input int j);
        return ((j >> s) << (s + 1)) | (j % (1 << s));
    endfunction

    function automatic int rev9(input int a);
        int r = 0;
        for (int i = 0; i < LG; i++) if ((a >> i) & 1) r |= 1 << (LG - 1 - i);
        return r;
    endfunction

    function automatic int par(input int a);
        int p = 0;
        for (int i = 0; i < LG; i++) p ^= (a >> i) & 1;
        return p;
    endfunction

    function automatic int tw_ref(input int s, input int j);
        return (j % (1 << s)) * (256 >> s);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_bfly(input int idx);
        int s = idx / NBF;
        int j = idx % NBF;
        int w0 = ins_zero(s, j);
        int w1 = w0 | (1 << s);
        int r0 = (s == 0) ? rev9(w0) : w0;
        int r1 = (s == 0) ? rev9(w1) : w1;
        chk("R1 busy", busy, 1);
        chk("R1 stage", stage_idx, s);
        chk("R1 bfly", bfly_idx, j);
        chk("R3 wr_addr0", wr_addr0, w0);
        chk("R3 wr_addr1", wr_addr1, w1);
        chk("R4 rd_addr0", rd_addr0, r0);
        chk("R4 rd_addr1", rd_addr1, r1);
        chk("R5 tw_addr", tw_addr, tw_ref(s, j));
        chk("R6 subs", {rd_sub0, rd_sub1, wr_sub0, wr_sub1},
            (par(r0) << 3) | (par(r1) << 2) | (par(w0) << 1) | par(w1));
        chk("R7 pairs", {rd_pair, wr_pair}, ((s % 2) << 1) | (1 - (s % 2)));
        chk("R8 done low", done, 0);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic walk(input int from, input int upto);
        for (int k = from; k < upto; k++) begin
            check_bfly(k);
            @(negedge clk);
        end
    endtask

    task automatic full_run();
        pulse_start();
        walk(0, TOTAL);
        chk("R8 done pulse", done, 1);
        chk("R8 busy low", busy, 0);
        chk("R8 counters cleared", {stage_idx, bfly_idx, rd_pair}, 0);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);
        chk("R8 idle", busy, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        chk("R2 reset state", {busy, done, stage_idx, bfly_idx, rd_pair}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 idle no start", {busy, done, stage_idx, bfly_idx}, 0);

        full_run();
        repeat (1 + $urandom_range(5)) @(negedge clk);

        for (int n = 0; n < 3; n++) begin
            int cut = 1 + $urandom_range(TOTAL - 2);
            pulse_start();
            walk(0, cut);
            pulse_start();
            chk("R2 restart stage", stage_idx, 0);
            chk("R2 restart bfly", bfly_idx, 0);
            chk("R2 restart pair", rd_pair, 0);
            walk(0, 300);
            repeat ($urandom_range(3)) @(negedge clk);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            chk("R2 reset mid-run", {busy, done, stage_idx, bfly_idx, rd_pair}, 0);
            @(negedge clk);
        end

        // restart in the last stage, then a clean complete run
        pulse_start();
        walk(0, TOTAL - 3);
        full_run();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<=200000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end
endmodule